// File: doc/BRIEF.md
# Alternating-Sign Period Difference Decimator

This block receives a stream of interval counts from a time-to-digital converter. The oscillator whose periods are measured alternates between a free-running cycle and a cycle that an injection pulse has disturbed, so the counts arrive in pairs at twice the reference rate, one count per measured period. The block gives one sample of each pair a positive sign and the other a negative sign. Each pair therefore contributes the difference between the two period types. That difference is the period error that steers the oscillator's tuning. Because both period types pass through the same measurement path, any constant offset in that path cancels within each pair.

The signed terms are summed over a window of 2^LOG2_PAIRS pairs. At the end of each window the total is emitted as a single error word with a one-cycle valid pulse, and the sum starts again from zero. This lowers the rate at which the slower tuning logic downstream must run. A phase-select input chooses which sample of a pair is negated. A synchronous restart discards the partial window and realigns the pair parity.

Top module: `pair_diff_decimator`

## Requirements
- R1: After the asynchronous reset (rst_n low), err_vld is 0 and err_word is 0.
- R2: With neg_first = 0, accepted samples at even positions in the window (counting from 0 after reset, restart or a dump) are added, and samples at odd positions are subtracted. Counts are unsigned.
- R3: The error word is ACC_W = CNT_W + LOG2_PAIRS + 1 bits, in two's complement. It is the exact signed total for every input pattern, including full-scale counts on one sign and zero counts on the other.
- R4: A dump occurs on the 2*2^LOG2_PAIRS-th accepted sample of a window. err_vld is high for exactly the one cycle after the clock edge that accepted that sample.
- R5: The sum clears at the dump. A sample accepted on the very next cycle is the first term (position 0) of the new window, and no sample is lost.
- R6: With neg_first = 1, the signs are swapped: even positions are subtracted and odd positions are added. neg_first is sampled with each accepted sample.
- R7: When count_vld is 0, count_in has no effect on the sum, on the position count or on the outputs.
- R8: restart = 1 clears the partial sum and the position count, returns the parity to position 0 and forces err_vld to 0 on the next cycle. A sample presented in the same cycle as restart is discarded.
- R9: err_word holds its last dumped value, or 0 after reset, until the next dump.
- R10: Adding the same constant to every count in a window leaves the dumped word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart of window and parity |
| neg_first | input | 1 | 1: negate the first sample of each pair; 0: negate the second |
| count_vld | input | 1 | count_in holds a new measurement |
| count_in | input | CNT_W | Unsigned interval count |
| err_vld | output | 1 | One-cycle pulse marking a new err_word |
| err_word | output | ACC_W | Signed sum of the last window |

## Verification
The bench sweeps count pairs in every polarity and checks each window against an arithmetic model. A sign error or a swapped phase select would show up as a wrong sum on nearly every window. Windows run back to back with no idle cycle, so a design that drops the sample after a dump, or adds it to the old window, gives shifted totals. Idle cycles with garbage counts, restarts in mid-window, and a restart that coincides with a valid sample are all exercised. A design that counted ignored data, kept a stale partial sum or misaligned the parity would dump early or with the wrong value. Full-scale one-sided windows reach the extremes of the word, so a narrow or wrapping accumulator would show the wrong sign.

// File: rtl/pdd_pkg.sv
package pdd_pkg;

  typedef enum logic {
    POL_POS = 1'b0,
    POL_NEG = 1'b1
  } pol_e;

  function automatic int sum_width(input int cnt_w, input int log2_pairs);
    return cnt_w + log2_pairs + 1;
  endfunction

endpackage

// File: rtl/pdd_sign.sv
module pdd_sign
  import pdd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int ACC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    smp_vld,
  input  logic [CNT_W-1:0]        smp,
  input  logic                    neg_first,
  output logic                    term_vld,
  output logic signed [ACC_W-1:0] term,
  output pol_e                    pol
);

  localparam int PAD_W = ACC_W - CNT_W;

  logic parity_q;

  function automatic logic signed [ACC_W-1:0] signed_term(
    input logic [CNT_W-1:0] v, input pol_e p);
    logic signed [ACC_W-1:0] ext;
    ext = $signed({{PAD_W{1'b0}}, v});
    return (p == POL_NEG) ? -ext : ext;
  endfunction

  assign pol      = pol_e'(parity_q ^ neg_first);
  assign term_vld = smp_vld & ~restart;
  assign term     = signed_term(smp, pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        parity_q <= 1'b0;
    else if (restart)  parity_q <= 1'b0;
    else if (smp_vld)  parity_q <= ~parity_q;
  end

  p_parity_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (parity_q == 1'b0));

  p_parity_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    term_vld |=> (parity_q != $past(parity_q)));

endmodule

// File: rtl/pdd_accum.sv
module pdd_accum #(
  parameter int CNT_W      = 8,
  parameter int LOG2_PAIRS = 3,
  parameter int ACC_W      = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    term_vld,
  input  logic signed [ACC_W-1:0] term,
  output logic                    dump_ev,
  output logic                    dump_vld,
  output logic signed [ACC_W-1:0] dump_word
);

  localparam int POS_W = LOG2_PAIRS + 1;
  localparam logic [POS_W-1:0] LAST_POS = {POS_W{1'b1}};
  localparam logic [ACC_W-1:0] MAXC = ACC_W'((1 << CNT_W) - 1);

  logic [POS_W-1:0]        pos_q;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] acc_next;

  function automatic logic [ACC_W-1:0] magnitude(input logic signed [ACC_W-1:0] v);
    return v[ACC_W-1] ? ACC_W'(-v) : ACC_W'(v);
  endfunction

  assign acc_next = acc_q + term;
  assign dump_ev  = term_vld & (pos_q == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q     <= '0;
      acc_q     <= '0;
      dump_vld  <= 1'b0;
      dump_word <= '0;
    end else if (restart) begin
      pos_q    <= '0;
      acc_q    <= '0;
      dump_vld <= 1'b0;
    end else begin
      dump_vld <= dump_ev;
      if (term_vld) begin
        pos_q <= pos_q + 1'b1;
        if (dump_ev) begin
          acc_q     <= '0;
          dump_word <= acc_next;
        end else begin
          acc_q <= acc_next;
        end
      end
    end
  end

  logic [ACC_W-1:0] bound;
  assign bound = ACC_W'(pos_q) * MAXC;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    magnitude(acc_q) <= bound);

  p_clear_after_dump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dump_ev && !restart) |=> (acc_q == '0 && pos_q == '0));

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (acc_q == '0 && !dump_vld));

endmodule

// File: rtl/pair_diff_decimator.sv
module pair_diff_decimator
  import pdd_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int LOG2_PAIRS = 3,
  parameter int ACC_W      = sum_width(CNT_W, LOG2_PAIRS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    neg_first,
  input  logic                    count_vld,
  input  logic [CNT_W-1:0]        count_in,
  output logic                    err_vld,
  output logic signed [ACC_W-1:0] err_word
);

  logic                    term_vld;
  logic signed [ACC_W-1:0] term;
  pol_e                    pol;
  logic                    dump_ev;

  pdd_sign #(.CNT_W(CNT_W), .ACC_W(ACC_W)) u_sign (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .smp_vld  (count_vld),
    .smp      (count_in),
    .neg_first(neg_first),
    .term_vld (term_vld),
    .term     (term),
    .pol      (pol)
  );

  pdd_accum #(.CNT_W(CNT_W), .LOG2_PAIRS(LOG2_PAIRS), .ACC_W(ACC_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .term_vld (term_vld),
    .term     (term),
    .dump_ev  (dump_ev),
    .dump_vld (err_vld),
    .dump_word(err_word)
  );

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |=> !err_vld);

  p_pulse_follows_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> ($past(count_vld) && !$past(restart)));

  p_word_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |-> $stable(err_word));

  p_idle_no_dump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !count_vld |=> !err_vld);

endmodule

// File: tb/test_pair_diff_decimator.sv
`timescale 1ns/1ps
module test_pair_diff_decimator;

  localparam int CW  = 4;
  localparam int LP  = 1;
  localparam int AW  = CW + LP + 1;
  localparam int WIN = 2 * (1 << LP);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic neg_first = 1'b0;
  logic count_vld = 1'b0;
  logic [CW-1:0] count_in = '0;
  logic err_vld;
  logic signed [AW-1:0] err_word;

  int vectors = 0;
  int fails = 0;
  int m_sum = 0;
  int m_pos = 0;
  int m_word = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  pair_diff_decimator #(.CNT_W(CW), .LOG2_PAIRS(LP)) i_pair_diff_decimator (
    .clk(clk), .rst_n(rst_n), .restart(restart), .neg_first(neg_first),
    .count_vld(count_vld), .count_in(count_in),
    .err_vld(err_vld), .err_word(err_word)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input string req, input bit v, input int val,
                      input bit nf, input bit rs);
    bit exp_vld;
    @(negedge clk);
    count_vld = v; count_in = CW'(val); neg_first = nf; restart = rs;
    exp_vld = 1'b0;
    if (rs) begin
      m_sum = 0; m_pos = 0;
    end else if (v) begin
      m_sum += ((((m_pos % 2) != 0) ^ nf) ? -val : val);
      m_pos++;
      if (m_pos == WIN) begin
        exp_vld = 1'b1; m_word = m_sum; m_sum = 0; m_pos = 0;
      end
    end
    @(posedge clk);
    #1;
    check(req, int'(err_vld), int'(exp_vld));
    check(exp_vld ? req : "R9", int'(err_word), m_word);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", int'(err_vld), 0);
    check("R1", int'(err_word), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 / R5: back-to-back windows sweeping value pairs, positive-first
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        step("R2", 1, a, 0, 0);
        step("R2", 1, b, 0, 0);
        step("R5", 1, 15 - a, 0, 0);
        step("R4", 1, (3 * a + b) % 16, 0, 0);
      end

    // R6: negative-first sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b += 3) begin
        step("R6", 1, a, 1, 0);
        step("R6", 1, b, 1, 0);
        step("R6", 1, (a + 7) % 16, 1, 0);
        step("R6", 1, (b * 5) % 16, 1, 0);
      end

    // R3: full-scale extremes
    for (int k = 0; k < WIN; k++) step("R3", 1, (k % 2 == 0) ? 15 : 0, 0, 0);
    for (int k = 0; k < WIN; k++) step("R3", 1, (k % 2 == 0) ? 0 : 15, 0, 0);
    for (int k = 0; k < WIN; k++) step("R3", 1, (k % 2 == 0) ? 0 : 15, 1, 0);

    // R7: idle cycles with garbage interleaved
    for (int k = 0; k < 3 * WIN; k++) begin
      step("R7", 0, 15 - k % 16, k % 2, 0);
      step("R7", 1, k % 16, 0, 0);
      step("R7", 0, 9, 1, 0);
    end

    // R8: restart mid-window, restart with a valid sample
    step("R8", 1, 11, 0, 0);
    step("R8", 1, 2, 0, 0);
    step("R8", 1, 7, 0, 0);
    step("R8", 1, 13, 0, 1);
    for (int k = 0; k < WIN; k++) step("R8", 1, k + 3, 0, 0);
    step("R8", 1, 4, 0, 0);
    step("R8", 0, 0, 0, 1);
    for (int k = 0; k < WIN; k++) step("R8", 1, 12 - k, 0, 0);

    // R10: constant offset cancels
    for (int c = 0; c < 16; c += 5)
      for (int k = 0; k < WIN; k++) step("R10", 1, c, 0, 0);
    for (int k = 0; k < WIN; k++) step("R10", 1, (k % 2 == 0) ? 3 : 9, 0, 0);
    for (int k = 0; k < WIN; k++) step("R10", 1, (k % 2 == 0) ? 8 : 14, 0, 0);

    // R9: long idle hold
    for (int k = 0; k < 10; k++) step("R9", 0, k, 0, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule